// File: doc/BRIEF.md
# Circular Capture Address Counter

This block produces the address for a circular sample-capture memory of 2^15 entries. In capture (write) mode the address steps forward on every sample tick and rolls over from the top entry back to zero. The buffer therefore always holds the most recent 32K samples. When a trigger pulse arrives, the address current at that moment is copied into a holding register. Afterwards the host reads that register to find which entry holds the trigger sample.

In readout (read) mode the host first presets the counter with a start address through a 16-bit write. It then reads the memory one entry at a time, and the address moves on by one after each read completes. Both modes are gated by an external active-low stop input. While that input is low the address does not advance, but a host preset still takes effect.

All activity is synchronous to one clock. The sample rate and the host accesses arrive as single-cycle enables.

Top module: `capaddr_top`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets both `addr` and `trigAddr` to 0.
- R2: With `writeMode`=1, `stopN`=1 and `sampleEn`=1, `addr` increases by 1 at the clock edge. It wraps from 32767 to 0.
- R3: With `writeMode`=1 and `trigPulse`=1, `trigAddr` takes the value `addr` had before that edge. Any advance of `addr` in the same cycle does not affect the captured value.
- R4: `trigAddr` keeps its value in every cycle that has no write-mode trigger. This includes `trigPulse` in read mode and all read-mode host activity.
- R5: With `writeMode`=0, the load bit `ctrlLoadN`=0, the read-clock bit `ctrlRdClkN`=0 and `hostWr`=1, `addr` becomes `hostData[14:0]`. Bit 15 of `hostData` is ignored. The load takes effect whatever the state of `stopN`, and it wins over a read increment in the same cycle.
- R6: With `writeMode`=0, the read-memory bit `ctrlRdMemN`=0, `ctrlRdClkN`=0, `hostRd`=1 (a host read completes), `stopN`=1 and no load, `addr` increases by 1, wrapping from 32767 to 0.
- R7: While `stopN`=0, `addr` never increments in either mode.
- R8: In write mode `hostWr` and `hostRd` have no effect. In read mode `sampleEn` has no effect. A read-mode load or increment needs `ctrlRdClkN`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| writeMode | input | 1 | 1 = capture mode, 0 = readout mode |
| ctrlLoadN | input | 1 | Active-low preset-select control bit |
| ctrlRdClkN | input | 1 | Active-low read-clock select control bit |
| ctrlRdMemN | input | 1 | Active-low read-memory control bit |
| hostWr | input | 1 | Host write strobe, one cycle |
| hostData | input | 16 | Host preset value |
| hostRd | input | 1 | Host read completion strobe, one cycle |
| sampleEn | input | 1 | Sample-rate tick |
| trigPulse | input | 1 | Trigger event |
| stopN | input | 1 | Active-low stop (count enable when high) |
| addr | output | 15 | Capture memory address |
| trigAddr | output | 15 | Address latched at the last trigger |

## Verification
The bench builds the block with its default widths: a 15-bit address and 16-bit host data. With those widths the bench can drive 32768 write-mode ticks in a single sweep, so the natural rollover in capture mode is reached without a preset. Presetting 32767 brings the readout rollover within a couple of reads. The 16-bit data width leaves a spare top bit, which lets the bench show that bit 15 is dropped on load.

// File: rtl/capaddr_pkg.sv
package capaddr_pkg;
  typedef struct packed {
    logic load;
    logic advance;
    logic capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/capaddr_ctrl.sv
module capaddr_ctrl
  import capaddr_pkg::*;
(
  input  logic         writeMode,
  input  logic         ctrlLoadN,
  input  logic         ctrlRdClkN,
  input  logic         ctrlRdMemN,
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic         sampleEn,
  input  logic         trigPulse,
  input  logic         stopN,
  output ctrlStrobes_t strobes
);
  logic readPath;
  logic loadHit;
  logic readHit;
  logic sampleHit;

  always_comb begin
    readPath  = !writeMode && !ctrlRdClkN;
    loadHit   = readPath && !ctrlLoadN && hostWr;
    readHit   = readPath && !ctrlRdMemN && hostRd;
    sampleHit = writeMode && sampleEn;
    strobes.load    = loadHit;
    strobes.advance = !loadHit && stopN && (readHit || sampleHit);
    strobes.capture = writeMode && trigPulse;
  end
endmodule

// File: rtl/capaddr_dpath.sv
module capaddr_dpath
  import capaddr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] loadData,
  output logic [ADDR_W-1:0] addrQ,
  output logic [ADDR_W-1:0] trigQ
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    if (strobes.load)         addrNext = loadData[ADDR_W-1:0];
    else if (strobes.advance) addrNext = addrQ + ADDR_ONE;
    else                      addrNext = addrQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      trigQ <= '0;
    end else begin
      addrQ <= addrNext;
      if (strobes.capture) trigQ <= addrQ;
    end
  end
endmodule

// File: rtl/capaddr_top.sv
module capaddr_top
  import capaddr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              writeMode,
  input  logic              ctrlLoadN,
  input  logic              ctrlRdClkN,
  input  logic              ctrlRdMemN,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostRd,
  input  logic              sampleEn,
  input  logic              trigPulse,
  input  logic              stopN,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] trigAddr
);
  ctrlStrobes_t strobes;

  capaddr_ctrl u_ctrl (
    .writeMode (writeMode),
    .ctrlLoadN (ctrlLoadN),
    .ctrlRdClkN(ctrlRdClkN),
    .ctrlRdMemN(ctrlRdMemN),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .sampleEn  (sampleEn),
    .trigPulse (trigPulse),
    .stopN     (stopN),
    .strobes   (strobes)
  );

  capaddr_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .loadData(hostData),
    .addrQ   (addr),
    .trigQ   (trigAddr)
  );
endmodule

// File: rtl/capaddr_chk.sv
module capaddr_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              writeMode,
  input logic              ctrlLoadN,
  input logic              ctrlRdClkN,
  input logic              ctrlRdMemN,
  input logic              hostWr,
  input logic [DATA_W-1:0] hostData,
  input logic              hostRd,
  input logic              sampleEn,
  input logic              trigPulse,
  input logic              stopN,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] trigAddr
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic loadCond;
  assign loadCond = !writeMode && !ctrlLoadN && !ctrlRdClkN && hostWr;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (addr == '0 && trigAddr == '0));

  assert_write_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (writeMode && sampleEn && stopN && addr == TOP) |=> addr == '0);

  assert_write_step_R2: assert property (@(posedge clk) disable iff (rst)
    (writeMode && sampleEn && stopN) |=> addr == $past(addr) + 1'b1);

  assert_trig_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (writeMode && trigPulse) |=> trigAddr == $past(addr));

  assert_trig_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(writeMode && trigPulse) |=> $stable(trigAddr));

  assert_host_load_R5: assert property (@(posedge clk) disable iff (rst)
    loadCond |=> addr == $past(hostData[ADDR_W-1:0]));

  assert_read_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!writeMode && !ctrlRdMemN && !ctrlRdClkN && hostRd && stopN && !loadCond)
      |=> addr == $past(addr) + 1'b1);

  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!stopN && !loadCond) |=> $stable(addr));

  assert_read_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!writeMode && (ctrlRdClkN || (!hostWr && !hostRd))) |=> $stable(addr));
endmodule

bind capaddr_top capaddr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_capaddr_top.sv
module sim_capaddr_top;
  localparam int AW = 15;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst, writeMode, ctrlLoadN, ctrlRdClkN, ctrlRdMemN;
  logic hostWr, hostRd, sampleEn, trigPulse, stopN;
  logic [DW-1:0] hostData;
  logic [AW-1:0] addr, trigAddr;
  logic [AW-1:0] expAddr, expTrig;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  capaddr_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  function automatic logic [AW-1:0] modelAddr(logic [AW-1:0] cur);
    logic ld;
    ld = !writeMode && !ctrlLoadN && !ctrlRdClkN && hostWr;
    if (rst) return '0;
    if (ld) return hostData[AW-1:0];
    if (stopN && ((writeMode && sampleEn) ||
                  (!writeMode && !ctrlRdClkN && !ctrlRdMemN && hostRd)))
      return cur + 1'b1;
    return cur;
  endfunction

  function automatic logic [AW-1:0] modelTrig(logic [AW-1:0] cur, logic [AW-1:0] a);
    if (rst) return '0;
    if (writeMode && trigPulse) return a;
    return cur;
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    rst = 0; writeMode = 1; ctrlLoadN = 1; ctrlRdClkN = 1; ctrlRdMemN = 1;
    hostWr = 0; hostRd = 0; sampleEn = 0; trigPulse = 0; stopN = 1; hostData = '0;
  endtask

  // inputs are already set at a negedge; advance one edge and update model
  task automatic step();
    logic [AW-1:0] na, nt;
    na = modelAddr(expAddr);
    nt = modelTrig(expTrig, expAddr);
    @(posedge clk);
    @(negedge clk);
    expAddr = na;
    expTrig = nt;
  endtask

  task automatic loadVal(logic [DW-1:0] v);
    idle(); writeMode = 0; ctrlLoadN = 0; ctrlRdClkN = 0; hostWr = 1; hostData = v;
    step(); idle(); writeMode = 0;
  endtask

  task automatic readOnce();
    idle(); writeMode = 0; ctrlRdClkN = 0; ctrlRdMemN = 0; hostRd = 1;
    step(); idle(); writeMode = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    expAddr = 'x; expTrig = 'x;
    idle(); rst = 1;
    @(negedge clk);
    step(); step();
    rst = 0;
    check("R1 reset addr", addr, '0);
    check("R1 reset trigAddr", trigAddr, '0);

    // R2 full circulation in write mode
    idle(); sampleEn = 1;
    for (int i = 0; i < 32767; i++) step();
    check("R2 top of range", addr, 15'd32767);
    step();
    check("R2 write wrap to 0", addr, '0);

    // R3 trigger captures pre-advance address
    idle(); sampleEn = 1; step(); step(); step();
    trigPulse = 1; step();
    check("R3 trig capture", trigAddr, 15'd3);
    check("R2 advance alongside trigger", addr, 15'd4);

    // R7 stop holds in write mode
    idle(); sampleEn = 1; stopN = 0; step(); step();
    check("R7 write stop hold", addr, 15'd4);

    // R5 load with bit15 set; R4 trig unaffected
    loadVal(16'hC123);
    check("R5 load drops bit15", addr, 15'h4123);
    check("R4 trig hold after load", trigAddr, 15'd3);

    // R6 post-increment and wrap
    loadVal(16'h7FFF);
    readOnce();
    check("R6 read wrap", addr, '0);
    readOnce(); readOnce();
    check("R6 read increment", addr, 15'd2);

    // R7 stop in read mode, R5 load ignores stop
    idle(); writeMode = 0; ctrlRdClkN = 0; ctrlRdMemN = 0; hostRd = 1; stopN = 0; step();
    check("R7 read stop hold", addr, 15'd2);
    idle(); writeMode = 0; ctrlLoadN = 0; ctrlRdClkN = 0; hostWr = 1; stopN = 0;
    hostData = 16'd500; step();
    check("R5 load under stop", addr, 15'd500);

    // R5 load wins over read increment
    idle(); writeMode = 0; ctrlLoadN = 0; ctrlRdClkN = 0; ctrlRdMemN = 0;
    hostWr = 1; hostRd = 1; hostData = 16'd77; step();
    check("R5 load priority", addr, 15'd77);

    // R8 isolation
    idle(); writeMode = 0; sampleEn = 1; step();
    check("R8 read ignores sampleEn", addr, 15'd77);
    idle(); writeMode = 0; ctrlRdMemN = 0; ctrlLoadN = 0; hostRd = 1; hostWr = 1;
    hostData = 16'd9; step();
    check("R8 rdclk high blocks", addr, 15'd77);
    idle(); writeMode = 1; ctrlLoadN = 0; ctrlRdClkN = 0; ctrlRdMemN = 0;
    hostWr = 1; hostRd = 1; hostData = 16'd9; step();
    check("R8 write ignores host", addr, 15'd77);

    // R4 trigger in read mode ignored
    idle(); writeMode = 0; trigPulse = 1; step();
    check("R4 read-mode trigger ignored", trigAddr, 15'd3);

    // random phase against model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] pa, pt;
      logic [31:0] r;
      r = $urandom();
      rst = (r[3:0] == 0) && (r[9:4] == 0);
      writeMode = r[4]; ctrlLoadN = r[5]; ctrlRdClkN = r[6] & r[7];
      ctrlRdMemN = r[8] & r[9]; hostWr = r[10] & r[11]; hostRd = r[12];
      sampleEn = r[13]; trigPulse = r[14] & r[15]; stopN = r[16] | r[17];
      hostData = 16'($urandom());
      pa = expAddr; pt = expTrig;
      step();
      check("R2 R6 model addr", addr, expAddr);
      check("R3 R4 model trigAddr", trigAddr, expTrig);
      if (pa == 15'h7FFF && expAddr == 0) check("R2 random wrap", addr, '0);
      if (pt != expTrig) check("R3 random capture", trigAddr, expTrig);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule